// File: doc/BRIEF.md
# Emergency Stop Restart Supervisor

This block decides when a machine may be commanded to run after an emergency stop. It watches a stop-circuit health input and an external trip flag, and accepts operator start and reset pushbuttons. The health input is active high: it reads 1 while the normally closed stop circuit is intact. A pressed button, a power loss or a broken wire all read 0. The block drives a run command and a flag that shows a reset is still owed.

When the stop circuit opens, the run command drops and a pending-reset latch is set. Closing the circuit again does not restart anything. The operator must press reset while the circuit is healthy, and then give a fresh start press. The pending-reset latch is set out of reset, so the first start after power-up also needs a reset first. A trip drops the run command but does not set the latch.

All inputs are sampled on the rising clock edge. Each output changes one cycle after the input sample that causes it.

Top module: `estop_restart_sup`

## Requirements
- R1: After synchronous reset (rst_n low), run_cmd is 0 and rst_pending is 1.
- R2: Any cycle in which stop_ok is 0 sets rst_pending to 1 on the next cycle.
- R3: rst_pending clears on the next cycle only when reset_btn is 1 and stop_ok is 1 in the same sample. A reset_btn press while stop_ok is 0 leaves rst_pending at 1.
- R4: A rising edge of start_btn (1 now, 0 in the previous sample) sets run_cmd on the next cycle when, in that sample, stop_ok is 1, rst_pending is 0 and trip_act is 0.
- R5: A start_btn rising edge that occurs while rst_pending is 1, trip_act is 1 or stop_ok is 0 is ignored, and run_cmd stays 0.
- R6: Once set, run_cmd stays 1 after start_btn is released, for as long as stop_ok is 1 and trip_act is 0.
- R7: stop_ok at 0 clears run_cmd on the next cycle. This overrides the seal-in.
- R8: trip_act at 1 clears run_cmd on the next cycle.
- R9: Restoring stop_ok never sets run_cmd. A start_btn held down through the reset press does not set run_cmd; a new press is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_ok | input | 1 | Stop-circuit health, 1 when intact |
| start_btn | input | 1 | Start pushbutton |
| reset_btn | input | 1 | Manual reset pushbutton |
| trip_act | input | 1 | External trip flag |
| run_cmd | output | 1 | Run command to the equipment |
| rst_pending | output | 1 | A manual reset is still required |

## Verification
The hardest case to reach is a start button held continuously from before the reset press until after the pending-reset latch has cleared. Here the start level is high while every other enabling condition holds, but no new edge arrives. The stimulus presses start while the latch is still set, adds reset on top, and then releases only reset. The run command must stay low until start is released and pressed again. A reset press made while the stop circuit is still open is also driven, to show that the latch does not clear.

// File: rtl/estop_pkg.sv
package estop_pkg;
   typedef struct packed {
      logic stop_ok;
      logic start_btn;
      logic reset_btn;
      logic trip_act;
   } estop_in_t;

   localparam int unsigned ESTOP_IN_W = $bits(estop_in_t);
endpackage

// File: rtl/estop_edge_det.sv
module estop_edge_det #(
   parameter int unsigned WIDTH    = 1,
   parameter bit          IDLE_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);
   localparam logic [WIDTH-1:0] INIT_VEC = {WIDTH{IDLE_VAL}};

   if (WIDTH < 1) begin : g_bad_width
      $error("estop_edge_det: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= INIT_VEC;
      else        prev_q <= level_i;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign rise_o[i] = level_i[i] & ~prev_q[i];
   end
endmodule

// File: rtl/estop_reset_latch.sv
module estop_reset_latch #(
   parameter bit POWERUP_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic healthy_i,
   input  logic clear_req_i,
   output logic pending_o
);
   logic pending_q;
   logic pending_d;

   always_comb begin
      pending_d = pending_q;
      if (!healthy_i)       pending_d = 1'b1;
      else if (clear_req_i) pending_d = 1'b0;
   end

   if (POWERUP_SET) begin : g_init_set
      always_ff @(posedge clk) begin
         if (!rst_n) pending_q <= 1'b1;
         else        pending_q <= pending_d;
      end
   end else begin : g_init_clr
      always_ff @(posedge clk) begin
         if (!rst_n) pending_q <= 1'b0;
         else        pending_q <= pending_d;
      end
   end

   assign pending_o = pending_q;
endmodule

// File: rtl/estop_run_latch.sv
module estop_run_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic healthy_i,
   input  logic trip_i,
   input  logic pending_i,
   input  logic start_rise_i,
   output logic run_o
);
   logic run_q;
   logic run_d;
   logic drop;
   logic arm;

   assign drop = ~healthy_i | trip_i;
   assign arm  = start_rise_i & ~pending_i;

   always_comb begin
      if (drop)       run_d = 1'b0;
      else if (run_q) run_d = 1'b1;
      else            run_d = arm;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_d;
   end

   assign run_o = run_q;
endmodule

// File: rtl/estop_restart_sup.sv
module estop_restart_sup #(
   parameter bit POWERUP_LATCHED = 1'b1,
   parameter bit START_IDLE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_ok,
   input  logic start_btn,
   input  logic reset_btn,
   input  logic trip_act,
   output logic run_cmd,
   output logic rst_pending
);
   import estop_pkg::*;

   if (ESTOP_IN_W != 4) begin : g_bad_pkg
      $error("estop_restart_sup: unexpected input bundle width");
   end

   estop_in_t in_s;
   logic      start_rise;
   logic      pending;

   assign in_s = '{stop_ok: stop_ok, start_btn: start_btn,
                   reset_btn: reset_btn, trip_act: trip_act};

   estop_edge_det #(.WIDTH(1), .IDLE_VAL(START_IDLE_HIGH)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (in_s.start_btn),
      .rise_o  (start_rise)
   );

   estop_reset_latch #(.POWERUP_SET(POWERUP_LATCHED)) u_rlatch (
      .clk         (clk),
      .rst_n       (rst_n),
      .healthy_i   (in_s.stop_ok),
      .clear_req_i (in_s.reset_btn),
      .pending_o   (pending)
   );

   estop_run_latch u_run (
      .clk          (clk),
      .rst_n        (rst_n),
      .healthy_i    (in_s.stop_ok),
      .trip_i       (in_s.trip_act),
      .pending_i    (pending),
      .start_rise_i (start_rise),
      .run_o        (run_cmd)
   );

   assign rst_pending = pending;
endmodule

// File: rtl/estop_restart_sup_chk.sv
module estop_restart_sup_chk (
   input logic clk,
   input logic rst_n,
   input logic stop_ok,
   input logic start_btn,
   input logic reset_btn,
   input logic trip_act,
   input logic run_cmd,
   input logic rst_pending
);
   // R2
   open_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_ok |=> rst_pending);

   // R3
   clear_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pending) |-> $past(reset_btn && stop_ok));

   // R4
   run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_cmd) |-> $past(start_btn && stop_ok && !rst_pending && !trip_act));

   // R7
   open_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_ok |=> !run_cmd);

   // R8
   trip_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_act |=> !run_cmd);

   // R6
   seal_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cmd && stop_ok && !trip_act) |=> run_cmd);
endmodule

bind estop_restart_sup estop_restart_sup_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_ok     (stop_ok),
   .start_btn   (start_btn),
   .reset_btn   (reset_btn),
   .trip_act    (trip_act),
   .run_cmd     (run_cmd),
   .rst_pending (rst_pending)
);

// File: tb/sim_estop_restart_sup.sv
`timescale 1ns/1ps
module sim_estop_restart_sup;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_ok = 1'b1;
   logic start_btn = 1'b0;
   logic reset_btn = 1'b0;
   logic trip_act = 1'b0;
   logic run_cmd;
   logic rst_pending;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  run;
      logic  pend;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   estop_restart_sup u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop_ok     (stop_ok),
      .start_btn   (start_btn),
      .reset_btn   (reset_btn),
      .trip_act    (trip_act),
      .run_cmd     (run_cmd),
      .rst_pending (rst_pending)
   );

   task automatic drive(input logic ok, input logic st, input logic rs,
                        input logic tr, input logic e_run, input logic e_pend,
                        input string tag);
      exp_t e;
      @(negedge clk);
      stop_ok   = ok;
      start_btn = st;
      reset_btn = rs;
      trip_act  = tr;
      @(posedge clk);
      e.run  = e_run;
      e.pend = e_pend;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         exp_t e;
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (run_cmd !== e.run || rst_pending !== e.pend) begin
               errors++;
               $display("FAIL %s run=%b pend=%b expected run=%b pend=%b",
                        e.tag, run_cmd, rst_pending, e.run, e.pend);
            end
         end
      end
   end

   initial begin : watchdog
      #50000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      //          ok st rs tr  run pend
      drive(1, 0, 0, 0, 0, 1, "R1 reset state");
      drive(1, 1, 0, 0, 0, 1, "R5 start while pending");
      drive(1, 0, 0, 0, 0, 1, "R5 release");
      drive(0, 0, 1, 0, 0, 1, "R3 reset while open");
      drive(1, 0, 1, 0, 0, 0, "R3 reset while healthy");
      drive(1, 0, 0, 0, 0, 0, "R3 stays clear");
      drive(1, 1, 0, 1, 0, 0, "R5 start during trip");
      drive(1, 0, 0, 0, 0, 0, "R5 release after trip");
      drive(1, 1, 0, 0, 1, 0, "R4 start edge");
      drive(1, 0, 0, 0, 1, 0, "R6 seal after release");
      drive(1, 0, 0, 0, 1, 0, "R6 seal holds");
      drive(1, 0, 0, 1, 0, 0, "R8 trip drops run");
      drive(1, 0, 0, 0, 0, 0, "R8 trip cleared no restart");
      drive(1, 1, 0, 0, 1, 0, "R4 restart after trip");
      drive(1, 0, 0, 0, 1, 0, "R6 sealed");
      drive(0, 0, 0, 0, 0, 1, "R7 R2 open drops run");
      drive(0, 1, 0, 0, 0, 1, "R5 start while open");
      drive(1, 0, 0, 0, 0, 1, "R9 restore no restart");
      drive(1, 0, 0, 0, 0, 1, "R9 still idle");
      drive(1, 1, 0, 0, 0, 1, "R9 start held pending");
      drive(1, 1, 1, 0, 0, 0, "R9 reset with start held");
      drive(1, 1, 0, 0, 0, 0, "R9 held start no edge");
      drive(1, 1, 0, 0, 0, 0, "R9 held start still no run");
      drive(1, 0, 0, 0, 0, 0, "R9 release");
      drive(1, 1, 0, 0, 1, 0, "R4 fresh press");
      drive(0, 1, 0, 0, 0, 1, "R7 open with start held");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule